// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in an audio output path just ahead of the quantizer and fades each channel in or out so that starting or stopping playback makes no click. Every channel holds its own gain, from 0 (silent) to 256 (unity), and multiplies its incoming sample by that gain. Software starts a fade-in with an unmute command pulse or a fade-out with a mute command pulse. The engine then changes the gain by a programmable step size. A step happens once every programmable number of oversampled tick strobes, and the ramp continues until the gain reaches unity or zero.

Each channel's state machine has four states. MUTED (code 0) holds gain 0. RAMP_UP (code 1) raises the gain. UNMUTED (code 2) holds gain 256. RAMP_DN (code 4) lowers the gain. The state code is exported per channel so that software can wait for a stable state. The state is stable exactly when bits 0 and 2 of the code are both zero.

The transitions are as follows:
- MUTED to RAMP_UP on an unmute command.
- RAMP_UP to UNMUTED when the gain reaches 256.
- RAMP_UP to RAMP_DN on a mute command.
- UNMUTED to RAMP_DN on a mute command.
- RAMP_DN to MUTED when the gain reaches 0.
- RAMP_DN to RAMP_UP on an unmute command.

A reversal keeps the present gain. A per-channel bypass input passes samples through unscaled. The channels share the tick strobe, and each channel has its own commands, configuration and bypass.

Top module: `smute_top`

## Requirements
- R1: After reset every channel is in state code 0 with gain 0, and its output sample is 0.
- R2: The state code on `ramp_state` is 4 bits per channel: 0 = MUTED, 1 = RAMP_UP, 2 = UNMUTED, 4 = RAMP_DN, so bits 0 and 2 are both zero exactly in the stable states.
- R3: An unmute pulse in MUTED or RAMP_DN moves the channel to RAMP_UP at the next clock edge with the gain unchanged; in RAMP_UP or UNMUTED it has no effect.
- R4: A mute pulse in UNMUTED or RAMP_UP moves the channel to RAMP_DN at the next clock edge with the gain unchanged; in MUTED or RAMP_DN it has no effect; when mute and unmute are both high, mute takes priority and unmute is ignored.
- R5: While ramping, the gain changes only on a tick, and it changes once every P ticks, where P is the period field (0 acts as 1); the tick count restarts from zero whenever a command changes the state. A tick in the same cycle as such a command does not step.
- R6: In RAMP_UP, each step adds the step-size field to the gain, saturating at 256; reaching 256 enters UNMUTED at the same edge.
- R7: In RAMP_DN, each step subtracts the step-size field from the gain, saturating at 0; reaching 0 enters MUTED at the same edge.
- R8: With bypass low, the output one clock after a sample is presented equals sample times gain divided by 256, truncated toward zero (two's-complement samples).
- R9: With bypass high, the output one clock later equals the input sample unchanged, and the ramp state machine keeps running.
- R10: The channels are independent: commands, configuration and bypass of one channel do not affect another channel's state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampled tick strobe shared by all channels |
| smp_in | input | NCH*DW | Input samples, channel c in bits [c*DW +: DW], signed |
| cmd_unmute | input | NCH | Per-channel unmute command pulse |
| cmd_mute | input | NCH | Per-channel mute command pulse |
| step_size | input | NCH*CFG_W | Per-channel gain increment per step |
| step_period | input | NCH*CFG_W | Per-channel ticks per step |
| bypass | input | NCH | Per-channel scaling bypass |
| smp_out | output | NCH*DW | Scaled samples, registered, signed |
| ramp_state | output | NCH*4 | Per-channel state code |

## Verification
The main function is driven through a table of ramp-up runs. The runs combine step sizes from 1 to 255 with periods of 0, 1, 3, 4 and 13, and both positive and negative samples up to full scale. A mismatch in any run therefore points to a fault in the period counting, the saturation at unity, or the truncation toward zero on negative products. Because the other channel stays idle with a nonzero sample during every run, the same table shows whether one channel leaks into another. Directed sequences then feed commands in each state, including both commands at once, and a reversal in each direction with a partly used tick count. Together these separate a correct keep-gain reversal and counter restart from an engine that resets the gain or counts ticks across a command.

// File: rtl/smute_pkg.sv
`timescale 1ns/1ps
package smute_pkg;

    localparam int STATE_W = 4;

    // Codes are chosen so that bits 0 and 2 mark the ramping states.
    typedef enum logic [STATE_W-1:0] {
        ST_MUTED    = 4'd0,
        ST_RAMP_UP  = 4'd1,
        ST_UNMUTED  = 4'd2,
        ST_RAMP_DN  = 4'd4
    } ramp_state_e;

endpackage

// File: rtl/smute_ramp_fsm.sv
`timescale 1ns/1ps
module smute_ramp_fsm
    import smute_pkg::*;
#(
    parameter int GAIN_FRAC = 8,
    parameter int CFG_W     = 8,
    localparam int GW        = GAIN_FRAC + 1,
    localparam int SUM_W     = GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 cmd_up,
    input  logic                 cmd_dn,
    input  logic [CFG_W-1:0]     step_sz,
    input  logic [CFG_W-1:0]     step_per,
    output logic [GW-1:0]        gain_o,
    output logic [STATE_W-1:0]   state_o
);

    localparam logic [GW-1:0]    GAIN_FULL = GW'(1) << GAIN_FRAC;
    localparam logic [SUM_W-1:0] FULL_EXT  = SUM_W'(GAIN_FULL);

    ramp_state_e        state_q, state_n;
    logic [GW-1:0]      gain_q, gain_n;
    logic [CFG_W-1:0]   cnt_q, cnt_n;
    logic [CFG_W:0]     per_eff;
    logic               step_now;
    logic [SUM_W-1:0]   sum_up;
    logic [SUM_W-1:0]   step_ext;

    always_comb begin
        per_eff  = (step_per == '0) ? (CFG_W+1)'(1) : {1'b0, step_per};
        step_now = tick && (({1'b0, cnt_q} + (CFG_W+1)'(1)) >= per_eff);
        step_ext = SUM_W'(step_sz);
        sum_up   = SUM_W'(gain_q) + step_ext;
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MUTED;
            gain_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            gain_q  <= gain_n;
            cnt_q   <= cnt_n;
        end
    end

    // next-state and ramp arithmetic
    always_comb begin
        state_n = state_q;
        gain_n  = gain_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_MUTED: begin
                cnt_n = '0;
                if (cmd_up && !cmd_dn) begin
                    state_n = ST_RAMP_UP;
                end
            end
            ST_RAMP_UP: begin
                if (cmd_dn) begin
                    state_n = ST_RAMP_DN;
                    cnt_n   = '0;
                end else if (step_now) begin
                    cnt_n = '0;
                    if (sum_up >= FULL_EXT) begin
                        gain_n  = GAIN_FULL;
                        state_n = ST_UNMUTED;
                    end else begin
                        gain_n = sum_up[GW-1:0];
                    end
                end else if (tick) begin
                    cnt_n = cnt_q + CFG_W'(1);
                end
            end
            ST_UNMUTED: begin
                cnt_n = '0;
                if (cmd_dn) begin
                    state_n = ST_RAMP_DN;
                end
            end
            ST_RAMP_DN: begin
                if (cmd_up && !cmd_dn) begin
                    state_n = ST_RAMP_UP;
                    cnt_n   = '0;
                end else if (step_now) begin
                    cnt_n = '0;
                    if (SUM_W'(gain_q) <= step_ext) begin
                        gain_n  = '0;
                        state_n = ST_MUTED;
                    end else begin
                        gain_n = gain_q - GW'(step_sz);
                    end
                end else if (tick) begin
                    cnt_n = cnt_q + CFG_W'(1);
                end
            end
            default: begin
                state_n = ST_MUTED;
                gain_n  = '0;
                cnt_n   = '0;
            end
        endcase
    end

    // output process
    always_comb begin
        gain_o  = gain_q;
        state_o = state_q;
    end

    // R2
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q));

    // R6
    gain_le_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q <= GAIN_FULL);

    // R6
    unmuted_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNMUTED) |-> (gain_q == GAIN_FULL));

    // R7
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED) |-> (gain_q == '0));

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(gain_q));

    // R3
    unmute_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && cmd_up && !cmd_dn) |=> (state_q == ST_RAMP_UP));

    // R4
    mute_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_dn && (state_q == ST_UNMUTED || state_q == ST_RAMP_UP))
        |=> (state_q == ST_RAMP_DN && $stable(gain_q)));

endmodule

// File: rtl/smute_gain_scaler.sv
`timescale 1ns/1ps
module smute_gain_scaler #(
    parameter int DW        = 16,
    parameter int GAIN_FRAC = 8,
    localparam int GW        = GAIN_FRAC + 1,
    localparam int PW        = DW + GW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bypass,
    input  logic [GW-1:0]        gain,
    input  logic signed [DW-1:0] smp_in,
    output logic signed [DW-1:0] smp_out
);

    localparam logic signed [PW-1:0] ROUND_ADJ = PW'((1 << GAIN_FRAC) - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_adj;
    logic signed [PW-1:0] prod_sh;

    always_comb begin
        prod     = PW'(smp_in) * $signed({1'b0, gain});
        // bias negative products so the shift truncates toward zero
        prod_adj = prod[PW-1] ? (prod + ROUND_ADJ) : prod;
        prod_sh  = prod_adj >>> GAIN_FRAC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out <= '0;
        end else if (bypass) begin
            smp_out <= smp_in;
        end else begin
            smp_out <= prod_sh[DW-1:0];
        end
    end

    // R9
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (smp_out == $past(smp_in)));

    // R8
    silent_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && gain == '0) |=> (smp_out == '0));

endmodule

// File: rtl/smute_top.sv
`timescale 1ns/1ps
module smute_top
    import smute_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int DW        = 16,
    parameter int GAIN_FRAC = 8,
    parameter int CFG_W     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [NCH*DW-1:0]      smp_in,
    input  logic [NCH-1:0]         cmd_unmute,
    input  logic [NCH-1:0]         cmd_mute,
    input  logic [NCH*CFG_W-1:0]   step_size,
    input  logic [NCH*CFG_W-1:0]   step_period,
    input  logic [NCH-1:0]         bypass,
    output logic [NCH*DW-1:0]      smp_out,
    output logic [NCH*STATE_W-1:0] ramp_state
);

    localparam int GW = GAIN_FRAC + 1;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [GW-1:0]        gain_c;
        logic [STATE_W-1:0]   state_c;
        logic signed [DW-1:0] out_c;

        smute_ramp_fsm #(
            .GAIN_FRAC (GAIN_FRAC),
            .CFG_W     (CFG_W)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .cmd_up   (cmd_unmute[c]),
            .cmd_dn   (cmd_mute[c]),
            .step_sz  (step_size[c*CFG_W +: CFG_W]),
            .step_per (step_period[c*CFG_W +: CFG_W]),
            .gain_o   (gain_c),
            .state_o  (state_c)
        );

        smute_gain_scaler #(
            .DW        (DW),
            .GAIN_FRAC (GAIN_FRAC)
        ) u_scale (
            .clk     (clk),
            .rst_n   (rst_n),
            .bypass  (bypass[c]),
            .gain    (gain_c),
            .smp_in  (smp_in[c*DW +: DW]),
            .smp_out (out_c)
        );

        assign smp_out[c*DW +: DW]              = out_c;
        assign ramp_state[c*STATE_W +: STATE_W] = state_c;
    end

endmodule

// File: tb/tb_smute_top.sv
`timescale 1ns/1ps
module tb_smute_top;

    localparam int NCH = 2;
    localparam int DW  = 16;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [NCH*DW-1:0] smp_in = '0;
    logic [NCH-1:0]    cmd_unmute = '0;
    logic [NCH-1:0]    cmd_mute = '0;
    logic [NCH*CW-1:0] step_size = '0;
    logic [NCH*CW-1:0] step_period = '0;
    logic [NCH-1:0]    bypass = '0;
    logic [NCH*DW-1:0] smp_out;
    logic [NCH*4-1:0]  ramp_state;

    int n_vec = 0;
    int n_bad = 0;

    smute_top #(.NCH(NCH), .DW(DW), .GAIN_FRAC(8), .CFG_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .smp_in(smp_in),
        .cmd_unmute(cmd_unmute), .cmd_mute(cmd_mute),
        .step_size(step_size), .step_period(step_period),
        .bypass(bypass), .smp_out(smp_out), .ramp_state(ramp_state)
    );

    always #4 clk = ~clk;

    // fields: step[63:56] period[55:48] ticks[47:32] sample[31:0]
    localparam int TV_N = 6;
    localparam logic [63:0] TV [TV_N] = '{
        {8'd1,   8'd13, 16'd26, 32'sd16384},
        {8'd16,  8'd1,  16'd5,  -32'sd1000},
        {8'd100, 8'd1,  16'd3,  -32'sd32768},
        {8'd100, 8'd3,  16'd6,  32'sd12345},
        {8'd255, 8'd0,  16'd1,  -32'sd7},
        {8'd3,   8'd4,  16'd11, 32'sd32767}
    };

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int out_of(input int ch);
        return int'($signed(smp_out[ch*DW +: DW]));
    endfunction

    function automatic int st_of(input int ch);
        return int'(ramp_state[ch*4 +: 4]);
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse(input bit up, input bit dn);
        @(negedge clk);
        cmd_unmute[0] = up;
        cmd_mute[0]   = dn;
        @(negedge clk);
        cmd_unmute[0] = 1'b0;
        cmd_mute[0]   = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic set_cfg(input int s, input int p);
        step_size[0 +: CW]   = CW'(s);
        step_period[0 +: CW] = CW'(p);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // table walk: ramp-up runs on channel 0, channel 1 left idle
        for (int v = 0; v < TV_N; v++) begin
            int s, p, nt, smp, g, eo, es;
            s   = int'(TV[v][63:56]);
            p   = int'(TV[v][55:48]);
            nt  = int'(TV[v][47:32]);
            smp = int'($signed(TV[v][31:0]));
            do_reset();
            set_cfg(s, p);
            smp_in[0 +: DW]  = DW'(smp);
            smp_in[DW +: DW] = 16'sd5000;
            pulse(1'b1, 1'b0);
            ticks(nt);
            settle();
            g  = s * (nt / ((p == 0) ? 1 : p));
            if (g > 256) g = 256;
            eo = (smp * g) / 256;
            es = (g == 256) ? 2 : 1;
            check("R8 R5 table output", out_of(0), eo);
            check("R6 R2 table state", st_of(0), es);
            check("R10 idle channel output", out_of(1), 0);
            check("R10 idle channel state", st_of(1), 0);
        end

        // directed: reset
        smp_in[0 +: DW]  = 16'sd256;
        smp_in[DW +: DW] = 16'sd700;
        do_reset();
        settle();
        check("R1 reset state ch0", st_of(0), 0);
        check("R1 reset output ch0", out_of(0), 0);
        check("R1 reset state ch1", st_of(1), 0);

        // bypass while muted
        smp_in[0 +: DW] = -16'sd1234;
        bypass[0] = 1'b1;
        settle();
        check("R9 bypass output", out_of(0), -1234);
        check("R9 bypass keeps state", st_of(0), 0);
        bypass[0] = 1'b0;
        smp_in[0 +: DW] = 16'sd256;
        settle();
        check("R8 muted output", out_of(0), 0);

        // mute while muted is ignored
        set_cfg(16, 1);
        pulse(1'b0, 1'b1);
        settle();
        check("R4 mute in MUTED ignored", st_of(0), 0);

        // ramp up to gain 80
        pulse(1'b1, 1'b0);
        check("R3 R2 unmute enters RAMP_UP", st_of(0), 1);
        ticks(5);
        settle();
        check("R6 gain after 5 steps", out_of(0), 80);
        repeat (10) @(negedge clk);
        check("R5 no tick no change", out_of(0), 80);

        pulse(1'b1, 1'b0);
        settle();
        check("R3 unmute in RAMP_UP ignored state", st_of(0), 1);
        check("R3 unmute in RAMP_UP ignored gain", out_of(0), 80);

        // reversal to ramp down keeps gain
        pulse(1'b0, 1'b1);
        settle();
        check("R4 R2 mute reverses to RAMP_DN", st_of(0), 4);
        check("R4 reversal keeps gain", out_of(0), 80);
        ticks(1);
        settle();
        check("R7 step down", out_of(0), 64);

        // reversal back up with partial count, then down again
        set_cfg(16, 4);
        pulse(1'b1, 1'b0);
        check("R3 unmute in RAMP_DN reverses", st_of(0), 1);
        ticks(3);
        settle();
        check("R5 three of four ticks no step", out_of(0), 64);
        pulse(1'b0, 1'b1);
        ticks(3);
        settle();
        check("R5 count restarts after command", out_of(0), 64);
        ticks(1);
        settle();
        check("R7 step after full period", out_of(0), 48);

        // saturate to zero
        set_cfg(100, 1);
        ticks(1);
        settle();
        check("R7 floor at zero output", out_of(0), 0);
        check("R7 R2 reaches MUTED", st_of(0), 0);

        // both commands in MUTED: mute wins, unmute ignored
        pulse(1'b1, 1'b1);
        settle();
        check("R4 both commands in MUTED", st_of(0), 0);

        // ramp to full with saturation
        set_cfg(200, 1);
        pulse(1'b1, 1'b0);
        ticks(2);
        settle();
        check("R6 saturate to full", out_of(0), 256);
        check("R6 R2 reaches UNMUTED", st_of(0), 2);
        pulse(1'b1, 1'b0);
        settle();
        check("R3 unmute in UNMUTED ignored", st_of(0), 2);
        pulse(1'b1, 1'b1);
        settle();
        check("R4 both commands in UNMUTED", st_of(0), 4);
        check("R10 other channel untouched", st_of(1), 0);
        check("R10 other channel output", out_of(1), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule